// File: doc/BRIEF.md
# SECDED ECC Unit with Write-Path Error Injection

The unit sits between a 64-bit requester bus and a 72-bit memory word. Each write gets eight check bits: a 7-bit Hamming code over the data plus one bit of overall parity. Each read is decoded. A single flipped bit anywhere in the 72-bit word is repaired before the data goes back to the requester. Two flipped bits are detected but not repaired: the raw data is returned and marked bad.

For test, an injection enable and two 32-bit flip masks change the data bits on their way into memory. The check bits are always computed from the unmodified data, so the flips read back as genuine errors. The masks apply to every write while the enable is set, whatever the address.

Corrected errors are counted against a programmable threshold. One interrupt line reports two conditions: the count reaching the threshold, and any uncorrectable error. Sticky flags tell the two apart, and a write-1 pulse clears each flag.

Top module: `ecc_secded_inject`

## Requirements
- R1: While `inj_en` is 0, `mem_wr_data[63:0]` equals `wr_data`, whatever the mask values. `mem_wr_en` follows `wr_en` in the same cycle.
- R2: While `inj_en` is 1, a 1 in `inj_mask_hi[i]` inverts data bit 32+i and a 1 in `inj_mask_lo[i]` inverts data bit i, on every write.
  - The stored word has the layout: `[63:0]` data, `[70:64]` check bits, `[71]` overall parity.
  - The check bits are the XOR of the code positions of the set bits of the original, unmasked data.
  - Data bit j has as its code position the j-th integer, counting from 3, that is not a power of two.
  - The overall parity bit makes the XOR of all 72 stored bits zero.
- R3: `rd_valid`, `rd_data` and `rd_good` appear one cycle after `rd_en`. For a word with no error, or with one flipped bit, `rd_data` is the original data and `rd_good` is 1.
- R4: Each read with an odd overall parity counts as a single-bit error. This covers a flip in a data bit, a check bit or the parity bit.
  - The error sets `sbe_flag` and increments `sbe_count`, which saturates at its maximum.
  - It loads `last_syn` with the overall parity (bit 7) and the syndrome (bits 6:0). The syndrome is the stored check bits XOR the recomputed check bits.
- R5: Single-bit errors raise `irq` only in the cycle the updated count first becomes greater than or equal to `sbe_thresh`. `irq` then stays high.
- R6: A read with even overall parity and a nonzero syndrome is uncorrectable.
  - `rd_data` is the raw stored data and `rd_good` is 0.
  - `mbe_flag` is set, `last_syn` is loaded, and `irq` is high in the same cycle as `rd_valid`.
- R7: The flags are sticky.
  - A `clr_sbe` pulse clears `sbe_flag`, `sbe_count` and the pending threshold interrupt.
  - A `clr_mbe` pulse clears `mbe_flag`.
  - `irq` stays high until every flag that caused it has been cleared.
- R8: When a clear pulse and a new error of the same kind fall in the same cycle, the new error wins. The flag stays set, and for single-bit errors the count restarts at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write request |
| wr_data | input | 64 | Write data from requester |
| inj_en | input | 1 | Injection enable |
| inj_mask_hi | input | 32 | Flip mask for data bits 63:32 |
| inj_mask_lo | input | 32 | Flip mask for data bits 31:0 |
| mem_wr_en | output | 1 | Write strobe to memory |
| mem_wr_data | output | 72 | Encoded word to memory |
| rd_en | input | 1 | Read data from memory is valid |
| mem_rd_data | input | 72 | Encoded word from memory |
| rd_valid | output | 1 | Read result valid |
| rd_data | output | 64 | Read data to requester |
| rd_good | output | 1 | 1 when read data is correct |
| sbe_thresh | input | CNT_W | Single-bit error threshold |
| clr_sbe | input | 1 | Write-1 clear of single-bit flag and count |
| clr_mbe | input | 1 | Write-1 clear of multi-bit flag |
| sbe_flag | output | 1 | Sticky single-bit error flag |
| mbe_flag | output | 1 | Sticky uncorrectable error flag |
| sbe_count | output | CNT_W | Corrected error count |
| last_syn | output | 8 | Parity and syndrome of last error |
| irq | output | 1 | Shared interrupt level |

## Verification
A clear pulse and a new error of the same kind can arrive in the same cycle. The bench provokes this both in directed steps and in random reads, where it asserts `clr_sbe` or `clr_mbe` alongside a read of a word with one or two injected flips. It judges the result against a bench model in which the new event wins: the flag remains set, the count becomes 1, and the interrupt follows the threshold comparison on that restarted count.

// File: rtl/ecc_secded_inject.sv
module ecc_secded_inject #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [63:0]      wr_data,
  input  logic             inj_en,
  input  logic [31:0]      inj_mask_hi,
  input  logic [31:0]      inj_mask_lo,
  output logic             mem_wr_en,
  output logic [71:0]      mem_wr_data,
  input  logic             rd_en,
  input  logic [71:0]      mem_rd_data,
  output logic             rd_valid,
  output logic [63:0]      rd_data,
  output logic             rd_good,
  input  logic [CNT_W-1:0] sbe_thresh,
  input  logic             clr_sbe,
  input  logic             clr_mbe,
  output logic             sbe_flag,
  output logic             mbe_flag,
  output logic [CNT_W-1:0] sbe_count,
  output logic [7:0]       last_syn,
  output logic             irq
);

  function automatic logic [6:0] dpos(input int j);
    int n;
    logic [6:0] r;
    n = 0;
    r = '0;
    for (int p = 3; p < 72; p++) begin
      if ((p & (p - 1)) != 0) begin
        if (n == j) r = 7'(p);
        n++;
      end
    end
    return r;
  endfunction

  function automatic logic [7:0] enc(input logic [63:0] d);
    logic [6:0] c;
    c = '0;
    for (int j = 0; j < 64; j++)
      if (d[j]) c ^= dpos(j);
    return {(^d) ^ (^c), c};
  endfunction

  assign mem_wr_en   = wr_en;
  assign mem_wr_data = {enc(wr_data), wr_data ^ (inj_en ? {inj_mask_hi, inj_mask_lo} : 64'd0)};

  logic [7:0]       renc;
  logic [6:0]       syn;
  logic             podd, dbl;
  logic [63:0]      fix;
  logic             sbe_evt, mbe_evt;
  logic             thr_hit;
  logic [CNT_W-1:0] cnt_base, cnt_next;

  assign renc    = enc(mem_rd_data[63:0]);
  assign syn     = renc[6:0] ^ mem_rd_data[70:64];
  assign podd    = ^mem_rd_data;
  assign dbl     = !podd && (syn != 7'd0);
  assign sbe_evt = rd_en && podd;
  assign mbe_evt = rd_en && dbl;

  for (genvar j = 0; j < 64; j++) begin : g_fix
    assign fix[j] = podd && (syn == dpos(j));
  end

  always_comb begin
    cnt_base = clr_sbe ? '0 : sbe_count;
    cnt_next = cnt_base;
    if (sbe_evt && cnt_base != {CNT_W{1'b1}}) cnt_next = cnt_base + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid  <= 1'b0;
      rd_data   <= '0;
      rd_good   <= 1'b0;
      sbe_flag  <= 1'b0;
      mbe_flag  <= 1'b0;
      sbe_count <= '0;
      thr_hit   <= 1'b0;
      last_syn  <= '0;
    end else begin
      rd_valid  <= rd_en;
      if (rd_en) begin
        rd_data <= mem_rd_data[63:0] ^ fix;
        rd_good <= !dbl;
      end
      sbe_count <= cnt_next;
      sbe_flag  <= sbe_evt || (sbe_flag && !clr_sbe);
      thr_hit   <= (sbe_evt && cnt_next >= sbe_thresh) || (thr_hit && !clr_sbe);
      mbe_flag  <= mbe_evt || (mbe_flag && !clr_mbe);
      if (sbe_evt || mbe_evt) last_syn <= {podd, syn};
    end
  end

  assign irq = mbe_flag || thr_hit;

  p_inj_off_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !inj_en |-> mem_wr_data[63:0] == wr_data);
  p_rd_lat_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rd_valid);
  p_cnt_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en && !clr_sbe |=> $stable(sbe_count));
  p_mbe_irq_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && !rd_good |-> irq && mbe_flag);
  p_mbe_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    mbe_flag && !clr_mbe |=> mbe_flag);
  p_irq_src_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> sbe_flag || mbe_flag);
  p_clr_only_r8: assert property (@(posedge clk) disable iff (!rst_n)
    clr_sbe && !rd_en |=> sbe_count == '0 && !sbe_flag);

endmodule

// File: tb/tb_ecc_secded_inject.sv
`timescale 1ns/1ps
module tb_ecc_secded_inject;
  logic clk = 0, rst_n = 0;
  logic wr_en = 0, inj_en = 0, rd_en = 0, clr_sbe = 0, clr_mbe = 0;
  logic [63:0] wr_data = '0;
  logic [31:0] inj_mask_hi = '0, inj_mask_lo = '0;
  logic [71:0] mem_rd_data = '0;
  logic [7:0]  sbe_thresh = 8'd3;
  logic mem_wr_en, rd_valid, rd_good, sbe_flag, mbe_flag, irq;
  logic [71:0] mem_wr_data;
  logic [63:0] rd_data;
  logic [7:0]  sbe_count, last_syn;

  ecc_secded_inject #(.CNT_W(8)) dut (.*);

  always #2 clk = ~clk;

  int checks = 0, fails = 0;
  bit done = 0;
  logic [71:0] mem [16];
  logic [63:0] orig [16];
  bit m_sflag, m_mflag, m_thr;
  int m_cnt;

  function automatic logic [6:0] bpos(input int j);
    int k = 0;
    for (int p = 3; p < 72; p++) begin
      if ($countones(p) != 1) begin
        if (k == j) return 7'(p);
        k++;
      end
    end
    return 7'd0;
  endfunction

  function automatic logic [7:0] benc(input logic [63:0] d);
    logic [71:1] cw = '0;
    logic [6:0] c = '0;
    int k = 0;
    for (int p = 3; p < 72; p++)
      if ($countones(p) != 1) begin cw[p] = d[k]; k++; end
    for (int b = 0; b < 7; b++)
      for (int p = 3; p < 72; p++)
        if (p[b] && cw[p]) c[b] = ~c[b];
    return {$countones({d, c}) % 2 == 1, c};
  endfunction

  function automatic logic [6:0] fpos(input int idx);
    if (idx < 64) return bpos(idx);
    if (idx < 71) return 7'(1 << (idx - 64));
    return 7'd0;
  endfunction

  task automatic check(input string req, input logic [71:0] act, input logic [71:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_write(input int a, input logic [63:0] d, input bit en,
                          input logic [31:0] hi, input logic [31:0] lo);
    @(negedge clk);
    wr_en = 1; wr_data = d; inj_en = en; inj_mask_hi = hi; inj_mask_lo = lo;
    #1;
    mem[a] = mem_wr_data; orig[a] = d;
    check(en ? "R2 data" : "R1 data", mem_wr_data[63:0], en ? d ^ {hi, lo} : d);
    check("R2 check", mem_wr_data[71:64], benc(d));
    check("R1 strobe", mem_wr_en, 1);
    @(negedge clk);
    wr_en = 0; inj_en = 0; inj_mask_hi = '0; inj_mask_lo = '0;
  endtask

  task automatic do_read(input int a, input bit cs, input bit cm);
    logic [71:0] diff;
    logic [6:0] s;
    int n;
    bit sbe, mbe;
    diff = mem[a] ^ {benc(orig[a]), orig[a]};
    n = $countones(diff);
    s = '0;
    for (int i = 0; i < 72; i++) if (diff[i]) s ^= fpos(i);
    sbe = (n == 1);
    mbe = (n == 2);
    @(negedge clk);
    rd_en = 1; mem_rd_data = mem[a]; clr_sbe = cs; clr_mbe = cm;
    @(negedge clk);
    rd_en = 0; clr_sbe = 0; clr_mbe = 0;
    if (cs) begin m_cnt = 0; m_sflag = 0; m_thr = 0; end
    if (cm) m_mflag = 0;
    if (sbe) begin
      m_sflag = 1;
      if (m_cnt < 255) m_cnt++;
      if (m_cnt >= sbe_thresh) m_thr = 1;
    end
    if (mbe) m_mflag = 1;
    check("R3 valid", rd_valid, 1);
    check(mbe ? "R6 raw data" : "R3 data", rd_data, mbe ? mem[a][63:0] : orig[a]);
    check(mbe ? "R6 good" : "R3 good", rd_good, !mbe);
    check("R4 count", sbe_count, m_cnt);
    check(cs ? "R8 sbe flag" : "R4 sbe flag", sbe_flag, m_sflag);
    check(cm ? "R8 mbe flag" : "R6 mbe flag", mbe_flag, m_mflag);
    check("R5 irq", irq, m_thr || m_mflag);
    if (sbe || mbe) check(mbe ? "R6 syn" : "R4 syn", last_syn, {sbe, s});
  endtask

  task automatic do_clear(input bit cs, input bit cm);
    @(negedge clk);
    clr_sbe = cs; clr_mbe = cm;
    @(negedge clk);
    clr_sbe = 0; clr_mbe = 0;
    if (cs) begin m_cnt = 0; m_sflag = 0; m_thr = 0; end
    if (cm) m_mflag = 0;
    check("R7 sbe flag", sbe_flag, m_sflag);
    check("R7 count", sbe_count, m_cnt);
    check("R7 mbe flag", mbe_flag, m_mflag);
    check("R7 irq", irq, m_thr || m_mflag);
  endtask

  initial begin
    repeat (1000) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      repeat (189000) @(posedge clk);
      if (!done) begin
        checks++; fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
      end
    end
  end

  initial begin
    logic [31:0] seed;
    seed = $urandom(32'h5eed1234);
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R3 reset valid", rd_valid, 0);
    check("R7 reset irq", irq, 0);
    check("R4 reset count", sbe_count, 0);
    check("R7 reset flags", {sbe_flag, mbe_flag}, 0);

    // R1: masks ignored while disabled
    do_write(0, 64'h0123_4567_89ab_cdef, 0, 32'hffff_ffff, 32'h1);
    do_read(0, 0, 0);
    // R2/R4: single flip on bit 32 via hi mask
    do_write(1, 64'hdead_beef_cafe_f00d, 1, 32'h1, 32'h0);
    do_read(1, 0, 0);
    check("R5 below thresh", irq, 0);
    do_read(1, 0, 0);
    check("R5 below thresh", irq, 0);
    do_read(1, 0, 0);
    check("R5 at thresh", irq, 1);
    do_clear(1, 0);
    // R6: double flip via lo mask
    do_write(2, 64'h5555_aaaa_0f0f_f0f0, 1, 32'h0, 32'h3);
    do_read(2, 0, 0);
    check("R6 irq now", irq, 1);
    do_clear(0, 1);
    // R4: check bit and parity bit flips
    do_write(3, 64'h1, 0, '0, '0);
    mem[3][66] = ~mem[3][66];
    do_read(3, 0, 0);
    do_write(4, 64'h8000_0000_0000_0000, 0, '0, '0);
    mem[4][71] = ~mem[4][71];
    do_read(4, 0, 0);
    // R8: clear and new error in the same cycle
    do_read(1, 1, 0);
    check("R8 restart", sbe_count, 1);
    do_read(2, 0, 1);
    do_clear(1, 1);

    // random phase
    sbe_thresh = 8'd5;
    for (int it = 0; it < 300; it++) begin
      int a, b1, b2, k;
      logic [63:0] d, m;
      a = $urandom % 16;
      d = {$urandom, $urandom};
      k = $urandom % 3;
      b1 = $urandom % 64;
      b2 = (b1 + 1 + $urandom % 63) % 64;
      m = '0;
      if (k >= 1) m[b1] = 1;
      if (k == 2) m[b2] = 1;
      do_write(a, d, ($urandom % 4) != 0, m[63:32], m[31:0]);
      do_read(a, ($urandom % 8) == 0, ($urandom % 4) == 0);
      if (($urandom % 16) == 0) do_clear(1, 1);
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule